// File: doc/BRIEF.md
# DTMF Tone-Pair Frequency Validator

This block sits behind the two band-limited comparators of a touch-tone receiver. It takes one square wave from the low-frequency group and one from the high-frequency group, both resynchronised to a fixed reference clock. It measures each wave by counting reference cycles across a run of consecutive rising edges. It then decides whether the averaged period matches one of the four nominal tones of that group. When both groups hold the same recognised tone for two measurement windows in a row, it raises a signal-condition flag and presents the decoded row and column indices.

The flag is meant to drive a downstream steering and duration stage. That stage owns tone-duration and inter-digit pause qualification, so this block reports raw presence only. The flag drops as soon as either group loses validity, with no hold-off. A synchronous power-down input clears all measurement state.

The reference frequency and the number of periods per window are parameters. Every count window is derived from them when the block is elaborated.

Top module: `dtmf_pair_validator`

## Requirements
- R1: After reset, `sig_cond`, `row_idx` and `col_idx` are all 0.
- R2: Low-group tones map to `row_idx` as 697 Hz = 0, 770 Hz = 1, 852 Hz = 2 and 941 Hz = 3.
- R3: High-group tones map to `col_idx` as 1209 Hz = 0, 1336 Hz = 1, 1477 Hz = 2 and 1633 Hz = 3.
- R4: A tone whose frequency lies within 1.5 % plus 2 Hz of a nominal tone is accepted as that tone.
- R5: A tone 3.5 % or more away from every nominal tone is rejected. A tone in the band between the accept limit and the reject limit is also treated as invalid.
- R6: A measurement window spans `PERIODS` consecutive periods, counted from one rising edge to the `PERIODS`-th rising edge after it. Only the summed count is classified, so period-to-period jitter averages out.
- R7: A group is confirmed only after two consecutive windows classify to the same index. A burst long enough for a single window never raises `sig_cond`, and `sig_cond` only rises two cycles after a window completes.
- R8: `sig_cond` is 1 only while both groups are confirmed at the same time. One confirmed group alone leaves it at 0.
- R9: A group is invalidated when a window classifies as invalid, or when no rising edge arrives for longer than the group's longest valid window. `sig_cond` is 0 two cycles after either event.
- R10: While `sig_cond` is 0, `row_idx` and `col_idx` are 0.
- R11: While `pwr_dn` is 1, all measurement state is cleared, and on the following cycle `sig_cond`, `row_idx` and `col_idx` are 0. After release, detection restarts from an empty window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock; all counting is in its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_dn | input | 1 | Synchronous power-down; clears all state while high |
| lo_sq | input | 1 | Limited low-group square wave (asynchronous) |
| hi_sq | input | 1 | Limited high-group square wave (asynchronous) |
| sig_cond | output | 1 | Both groups hold a confirmed valid tone |
| row_idx | output | 2 | Low-group tone index, 0 while `sig_cond` is 0 |
| col_idx | output | 2 | High-group tone index, 0 while `sig_cond` is 0 |

## Verification
The bench walks all sixteen row and column pairs. A swapped compare constant or a bad encoder would show up there as a wrong index. It places one low tone just inside the accept limit and another in the dead band between the accept and reject limits. This catches a design that tests against the reject limit instead of the accept limit. An alternating short/long period with a valid average checks that classification uses the summed window and not a single period. A burst of exactly one window and a tone on one group only check that a design skipping the two-window match or the both-group condition would raise the flag. Stopping one tone and asserting power-down check that the flag falls within the edge-less timeout and is not left latched.

// File: rtl/dtmf_val_pkg.sv
package dtmf_val_pkg;

   localparam int NUM_TONES = 4;
   localparam int IDX_W     = 2;

   typedef struct packed {
      logic             hit;
      logic [IDX_W-1:0] idx;
   } tone_res_t;

   // Nominal tone frequency in Hz; grp 0 = low group, grp 1 = high group.
   function automatic int tone_hz(input int grp, input int k);
      int f;
      f = 0;
      if (grp == 0) begin
         case (k)
            0: f = 697;
            1: f = 770;
            2: f = 852;
            default: f = 941;
         endcase
      end else begin
         case (k)
            0: f = 1209;
            1: f = 1336;
            2: f = 1477;
            default: f = 1633;
         endcase
      end
      return f;
   endfunction

   // Shortest accepted window count: frequency at +1.5 % + 2 Hz.
   function automatic longint win_lo(input longint ref_hz, input int periods, input int f_hz);
      return (longint'(periods) * ref_hz * 1000) / (longint'(f_hz) * 1015 + 2000);
   endfunction

   // Longest accepted window count: frequency at -1.5 % - 2 Hz, rounded up.
   function automatic longint win_hi(input longint ref_hz, input int periods, input int f_hz);
      return (longint'(periods) * ref_hz * 1000) / (longint'(f_hz) * 985 - 2000) + 1;
   endfunction

endpackage

// File: rtl/dtmf_edge_sync.sv
module dtmf_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic din,
   output logic rise
);
   logic [STAGES:0] pipe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   pipe <= '0;
      else if (clr) pipe <= '0;
      else          pipe <= {pipe[STAGES-1:0], din};
   end

   assign rise = pipe[STAGES-1] & ~pipe[STAGES];
endmodule

// File: rtl/dtmf_window_meter.sv
module dtmf_window_meter #(
   parameter int     PERIODS = 4,
   parameter int     CW      = 16,
   parameter longint LIMIT   = 1000
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          rise,
   output logic          done,
   output logic          tmo,
   output logic [CW-1:0] win
);
   localparam int EW = (PERIODS > 2) ? $clog2(PERIODS) : 1;

   logic          armed;
   logic [CW-1:0] cnt;
   logic [EW-1:0] edges;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed <= 1'b0; cnt <= '0; edges <= '0;
         done <= 1'b0; tmo <= 1'b0; win <= '0;
      end else if (clr) begin
         armed <= 1'b0; cnt <= '0; edges <= '0;
         done <= 1'b0; tmo <= 1'b0; win <= '0;
      end else begin
         done <= 1'b0;
         tmo  <= 1'b0;
         if (rise) begin
            if (!armed) begin
               armed <= 1'b1;
               cnt   <= CW'(1);
               edges <= '0;
            end else if (edges == EW'(PERIODS - 1)) begin
               done  <= 1'b1;
               win   <= cnt;
               cnt   <= CW'(1);
               edges <= '0;
            end else begin
               edges <= edges + 1'b1;
               cnt   <= cnt + 1'b1;
            end
         end else if (armed) begin
            if (cnt > CW'(LIMIT)) begin
               tmo   <= 1'b1;
               armed <= 1'b0;
               cnt   <= '0;
               edges <= '0;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/dtmf_tone_classifier.sv
module dtmf_tone_classifier
   import dtmf_val_pkg::*;
#(
   parameter int GRP     = 0,
   parameter int REF_HZ  = 3579545,
   parameter int PERIODS = 4,
   parameter int CW      = 16
) (
   input  logic [CW-1:0] win,
   output tone_res_t     res
);
   logic [NUM_TONES-1:0] hit;

   for (genvar k = 0; k < NUM_TONES; k++) begin : g_tone
      localparam longint LO = win_lo(longint'(REF_HZ), PERIODS, tone_hz(GRP, k));
      localparam longint HI = win_hi(longint'(REF_HZ), PERIODS, tone_hz(GRP, k));
      assign hit[k] = (win >= CW'(LO)) && (win <= CW'(HI));
   end

   always_comb begin
      res.hit = |hit;
      res.idx = '0;
      for (int k = 0; k < NUM_TONES; k++) begin
         if (hit[k]) res.idx = IDX_W'(k);
      end
   end
endmodule

// File: rtl/dtmf_group_track.sv
module dtmf_group_track
   import dtmf_val_pkg::*;
#(
   parameter int GRP         = 0,
   parameter int REF_HZ      = 3579545,
   parameter int PERIODS     = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             sq,
   output logic             conf,
   output logic [IDX_W-1:0] idx,
   output logic             done,
   output logic             tmo
);
   // Longest valid window belongs to the lowest tone of the group.
   localparam longint LIMIT = win_hi(longint'(REF_HZ), PERIODS, tone_hz(GRP, 0));
   localparam int     CW    = $clog2(LIMIT + 3);

   logic             rise;
   logic [CW-1:0]    win;
   tone_res_t        res;
   logic             prev_ok;
   logic [IDX_W-1:0] prev_idx;

   dtmf_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .clr(clr), .din(sq), .rise(rise)
   );

   dtmf_window_meter #(.PERIODS(PERIODS), .CW(CW), .LIMIT(LIMIT)) u_meter (
      .clk(clk), .rst_n(rst_n), .clr(clr), .rise(rise),
      .done(done), .tmo(tmo), .win(win)
   );

   dtmf_tone_classifier #(.GRP(GRP), .REF_HZ(REF_HZ), .PERIODS(PERIODS), .CW(CW)) u_cls (
      .win(win), .res(res)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         conf <= 1'b0; prev_ok <= 1'b0; prev_idx <= '0;
      end else if (clr) begin
         conf <= 1'b0; prev_ok <= 1'b0; prev_idx <= '0;
      end else if (tmo) begin
         conf    <= 1'b0;
         prev_ok <= 1'b0;
      end else if (done) begin
         if (res.hit) begin
            conf     <= prev_ok && (prev_idx == res.idx);
            prev_ok  <= 1'b1;
            prev_idx <= res.idx;
         end else begin
            conf    <= 1'b0;
            prev_ok <= 1'b0;
         end
      end
   end

   assign idx = prev_idx;
endmodule

// File: rtl/dtmf_pair_validator.sv
module dtmf_pair_validator
   import dtmf_val_pkg::*;
#(
   parameter int REF_HZ      = 3579545,
   parameter int PERIODS     = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pwr_dn,
   input  logic             lo_sq,
   input  logic             hi_sq,
   output logic             sig_cond,
   output logic [IDX_W-1:0] row_idx,
   output logic [IDX_W-1:0] col_idx
);
   localparam int NGRP = 2;

   if (PERIODS < 2) begin : g_bad_periods
      $error("PERIODS must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (REF_HZ < 20000) begin : g_bad_ref
      $error("REF_HZ too low to resolve the tone tolerance");
   end

   logic [NGRP-1:0]            sq_in;
   logic [NGRP-1:0]            grp_conf;
   logic [NGRP-1:0]            grp_done;
   logic [NGRP-1:0]            grp_tmo;
   logic [NGRP-1:0][IDX_W-1:0] grp_idx;

   assign sq_in = {hi_sq, lo_sq};

   for (genvar g = 0; g < NGRP; g++) begin : g_grp
      dtmf_group_track #(
         .GRP(g), .REF_HZ(REF_HZ), .PERIODS(PERIODS), .SYNC_STAGES(SYNC_STAGES)
      ) u_trk (
         .clk(clk), .rst_n(rst_n), .clr(pwr_dn), .sq(sq_in[g]),
         .conf(grp_conf[g]), .idx(grp_idx[g]),
         .done(grp_done[g]), .tmo(grp_tmo[g])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sig_cond <= 1'b0; row_idx <= '0; col_idx <= '0;
      end else if (pwr_dn) begin
         sig_cond <= 1'b0; row_idx <= '0; col_idx <= '0;
      end else begin
         sig_cond <= &grp_conf;
         row_idx  <= (&grp_conf) ? grp_idx[0] : '0;
         col_idx  <= (&grp_conf) ? grp_idx[1] : '0;
      end
   end
endmodule

// File: rtl/dtmf_pair_validator_chk.sv
module dtmf_pair_validator_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       pwr_dn,
   input logic       sig_cond,
   input logic [1:0] row_idx,
   input logic [1:0] col_idx,
   input logic [1:0] grp_conf,
   input logic [1:0] grp_done,
   input logic [1:0] grp_tmo
);
   // R8: flag only follows a cycle where both groups were confirmed
   p_both_confirmed_r8: assert property (@(posedge clk) disable iff (!rst_n)
      sig_cond |-> $past(grp_conf == 2'b11));

   // R10: indices are quiet whenever the flag is low
   p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !sig_cond |-> (row_idx == 2'd0 && col_idx == 2'd0));

   // R11: power-down clears flag and confirmations on the next cycle
   p_pwrdn_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_dn |=> (!sig_cond && grp_conf == 2'b00));

   // R9: an edge-less timeout drops the flag two cycles later
   p_timeout_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (|grp_tmo) |-> ##2 !sig_cond);

   // R7: the flag only rises as the result of a completed window
   p_rise_after_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sig_cond) |-> $past(|grp_done, 2));
endmodule

bind dtmf_pair_validator dtmf_pair_validator_chk u_chk (
   .clk(clk), .rst_n(rst_n), .pwr_dn(pwr_dn), .sig_cond(sig_cond),
   .row_idx(row_idx), .col_idx(col_idx), .grp_conf(grp_conf),
   .grp_done(grp_done), .grp_tmo(grp_tmo)
);

// File: tb/sim_dtmf_pair_validator.sv
module sim_dtmf_pair_validator;
   localparam int REF   = 200000;
   localparam int PER_N = 4;
   localparam int WAITC = 5 * PER_N * 288;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pwr_dn = 1'b0;
   logic lo_sq = 1'b0;
   logic hi_sq = 1'b0;
   logic sig_cond;
   logic [1:0] row_idx, col_idx;

   int n_chk = 0;
   int n_fail = 0;
   int lo_per = 0, hi_per = 0, lo_jit = 0;
   int lo_left = -1, hi_left = -1;
   bit lo_flip = 1'b0;

   int lo_tab [4] = '{287, 260, 235, 213};
   int hi_tab [4] = '{165, 150, 135, 122};

   always #2 clk = ~clk;

   dtmf_pair_validator #(.REF_HZ(REF), .PERIODS(PER_N), .SYNC_STAGES(2)) u0 (
      .clk(clk), .rst_n(rst_n), .pwr_dn(pwr_dn), .lo_sq(lo_sq), .hi_sq(hi_sq),
      .sig_cond(sig_cond), .row_idx(row_idx), .col_idx(col_idx)
   );

   // low-group tone source, optional alternating jitter and burst length
   always begin : gen_lo
      if (lo_per == 0 || lo_left == 0) begin
         lo_sq = 1'b0;
         @(negedge clk);
      end else begin
         int p;
         p = lo_per + (lo_flip ? lo_jit : -lo_jit);
         lo_flip = !lo_flip;
         lo_sq = 1'b1;
         repeat (p / 2) @(negedge clk);
         lo_sq = 1'b0;
         repeat (p - p / 2) @(negedge clk);
         if (lo_left > 0) lo_left--;
      end
   end

   always begin : gen_hi
      if (hi_per == 0 || hi_left == 0) begin
         hi_sq = 1'b0;
         @(negedge clk);
      end else begin
         int p;
         p = hi_per;
         hi_sq = 1'b1;
         repeat (p / 2) @(negedge clk);
         hi_sq = 1'b0;
         repeat (p - p / 2) @(negedge clk);
         if (hi_left > 0) hi_left--;
      end
   end

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int outs();
      return {29'd0, sig_cond, row_idx, col_idx};
   endfunction

   function automatic int pack(input bit s, input int r, input int c);
      return (int'(s) << 4) | (r << 2) | c;
   endfunction

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   task automatic t_reset();
      wait_cyc(3);
      check("R1 reset outputs", outs(), 0);
   endtask

   // R2 and R3: every row/column pair decodes to its index
   task automatic t_all_pairs();
      for (int r = 0; r < 4; r++) begin
         for (int c = 0; c < 4; c++) begin
            lo_per = lo_tab[r];
            hi_per = hi_tab[c];
            wait_cyc(WAITC);
            check($sformatf("R2 R3 pair row%0d col%0d", r, c), outs(), pack(1'b1, r, c));
         end
      end
   endtask

   // R4: +1.39 % low tone and -1.23 % high tone are accepted
   task automatic t_accept_edge();
      lo_per = 283;
      hi_per = 124;
      wait_cyc(WAITC);
      check("R4 near accept limit", outs(), pack(1'b1, 0, 3));
   endtask

   // R6: alternating 280/294 periods average to a valid 697 Hz tone
   task automatic t_average();
      lo_per = 287;
      lo_jit = 7;
      hi_per = 150;
      wait_cyc(WAITC);
      check("R6 jittered periods averaged", outs(), pack(1'b1, 0, 1));
      lo_jit = 0;
   endtask

   // R5 and R10: rejected or dead-band tones give no flag and zero indices
   task automatic t_reject();
      lo_per = 276; hi_per = 165;
      wait_cyc(WAITC);
      check("R5 low +3.96 % rejected", outs(), 0);
      lo_per = 287; hi_per = 127;
      wait_cyc(WAITC);
      check("R5 high -3.56 % rejected", outs(), 0);
      lo_per = 229; hi_per = 165;
      wait_cyc(WAITC);
      check("R5 R10 dead band +2.5 % invalid", outs(), 0);
   endtask

   // R7: a burst covering exactly one window never raises the flag
   task automatic t_one_window();
      int seen;
      lo_per = 0; hi_per = 0;
      wait_cyc(1500);
      check("R9 silence clears flag", outs(), 0);
      seen = 0;
      lo_left = PER_N + 1;
      hi_left = PER_N + 1;
      lo_per = 260; hi_per = 150;
      for (int i = 0; i < 3000; i++) begin
         @(negedge clk);
         if (sig_cond) seen++;
      end
      check("R7 single window burst", seen, 0);
      lo_per = 0; hi_per = 0;
      lo_left = -1; hi_left = -1;
      wait_cyc(10);
   endtask

   // R9 and R8: losing the high tone drops the flag; low alone keeps it low
   task automatic t_drop();
      real lim;
      lim = 4.0 * REF / (1209.0 * 0.985 - 2.0);
      lo_per = lo_tab[0]; hi_per = hi_tab[0];
      wait_cyc(WAITC);
      check("R9 setup confirmed", outs(), pack(1'b1, 0, 0));
      hi_per = 0;
      wait_cyc(int'(lim) + 2 * 165 + 20);
      check("R9 R10 flag dropped after tone loss", outs(), 0);
      wait_cyc(3000);
      check("R8 low group alone", outs(), 0);
   endtask

   // R11: power-down clears and detection restarts after release
   task automatic t_power_down();
      lo_per = lo_tab[2]; hi_per = hi_tab[3];
      wait_cyc(WAITC);
      check("R11 setup confirmed", outs(), pack(1'b1, 2, 3));
      @(posedge clk);
      pwr_dn = 1'b1;
      wait_cyc(2);
      check("R11 cleared on power-down", outs(), 0);
      wait_cyc(3000);
      check("R11 held low during power-down", outs(), 0);
      pwr_dn = 1'b0;
      wait_cyc(WAITC);
      check("R11 reacquired after release", outs(), pack(1'b1, 2, 3));
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog (all R): actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin : main
      wait_cyc(5);
      rst_n = 1'b1;
      t_reset();
      t_all_pairs();
      t_accept_edge();
      t_average();
      t_reject();
      t_one_window();
      t_drop();
      t_power_down();
      summary();
      $finish;
   end
endmodule